// File: doc/BRIEF.md
# Host Mailbox Command Dispatcher

This block sits between a host processor and a serial bus engine. The host sees four word-wide registers on a simple write-strobe, combinational-read port: a command word, an arbitration byte, a status byte and a read-only identity word. The dispatcher watches the arbitration byte and the command word. It can hand the physical bus pins over to the host through a request and grant exchange. It can start a transfer or a break on the external serial engine. It can also produce a burst of idle clocks by itself. Each result goes back to the host as a status code, with a one-cycle interrupt pulse.

After reset the identity word fills in over three cycles: first the signature, then the firmware revision, then the interface revision. The host treats a non-zero interface revision as "ready". The dispatcher accepts no request before that point.

When a command is accepted, its opcode byte clears itself so the host can queue the next one. The upper bits of the command word stay in place as parameters. Requests that arrive while a command is running wait until it ends. Arbitration then takes precedence over any command still pending.

Top module: `mbx_dispatch`

## Requirements
- R1: After reset the status, arbitration byte and command word read 0, the interrupt is low, and the bus pins sit at idle: clock high, data high, data driven (`bus_dat_oe`=1), host ownership flag 0.
- R2: Right after reset the identity word reads 0. Within three clock edges it becomes {interface revision[31:24], firmware revision[23:16], signature[15:0]}. The interface revision byte never becomes non-zero before the other two fields hold their values.
- R3: While the dispatcher is idle, a non-zero arbitration byte is answered by overwriting it with the grant code 0x5A. From then on `bus_host_owns`=1 and `bus_dat_oe`=0.
- R4: While the grant is held, a pending command is not accepted. The command word keeps its opcode, the status is unchanged and no start is issued.
- R5: When the host writes 0 to the arbitration byte, the dispatcher takes the pins back one cycle later: ownership flag 0, data driven high, clock high.
- R6: If an arbitration request and a command are both pending when the dispatcher becomes idle, the arbitration request is served first.
- R7: Accepting a valid opcode sets the status to 1 (sending) and clears bits 7:0 of the command word. Bits 31:8 are kept, and exactly one start is issued.
- R8: Opcode 1 starts the engine with `eng_kind`=0 (transfer). Opcode 2 starts it with `eng_kind`=1 (break). `eng_param` carries command bits 31:8. While the engine runs, its pins drive the bus. On `eng_done` without `eng_timeout`, the status becomes 2 (complete) and the pins return to idle.
- R9: If `eng_timeout` is high together with `eng_done`, the status becomes 0x81 (no response).
- R10: Opcode 3 produces exactly N falling edges on `bus_clk`, where N is command bits 15:8. Each low phase lasts IDLE_HALF cycles. Data stays driven high throughout, and the status then becomes 2. N=0 gives no edges and goes straight to complete.
- R11: Any other non-zero opcode sets the status to 0x80 (invalid command), clears the opcode byte, and issues no start and no clocks.
- R12: `host_irq` pulses for one cycle each time the status is written with 2 or with a code of 0x80 or above, and at no other time.
- R13: While a command is running, a new command or an arbitration request stays pending, untouched, until the running command finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Register select: 0 command, 1 arbitration, 2 status, 3 identity |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Combinational read data of the selected register |
| host_irq | output | 1 | One-cycle pulse on a final status |
| eng_start | output | 1 | Start pulse to the serial engine |
| eng_kind | output | 1 | 0 transfer, 1 break |
| eng_param | output | DATA_W-8 | Command bits 31:8 |
| eng_done | input | 1 | Engine finished |
| eng_timeout | input | 1 | Engine saw no response (qualified by eng_done) |
| eng_clk | input | 1 | Engine clock pin value |
| eng_dat | input | 1 | Engine data pin value |
| eng_dat_oe | input | 1 | Engine data pin drive enable |
| bus_clk | output | 1 | Bus clock pin |
| bus_dat | output | 1 | Bus data pin value |
| bus_dat_oe | output | 1 | Bus data pin drive enable |
| bus_host_owns | output | 1 | Pins handed to the host |

## Verification
A wrong controller state shows at the pins or in the status byte within one or two cycles. A missed grant leaves the arbitration byte at the host's value and the ownership flag low. A stuck run state keeps the status at "sending" with no interrupt. A wrong opcode decode gives the wrong `eng_kind` in the cycle the start pulse appears. Errors in the idle-clock counter show up only as a wrong number or width of low phases on `bus_clk`, so the bench counts both at every cycle of a burst. A self-clear that hits the wrong byte corrupts `eng_param` on the next read of the command word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int OP_W  = 8;
  localparam int CNT_W = 8;

  localparam logic [7:0] ST_IDLE       = 8'h00;
  localparam logic [7:0] ST_SENDING    = 8'h01;
  localparam logic [7:0] ST_DONE       = 8'h02;
  localparam logic [7:0] ST_ERR_BADOP  = 8'h80;
  localparam logic [7:0] ST_ERR_NORESP = 8'h81;

  localparam logic [7:0] OP_XFER   = 8'h01;
  localparam logic [7:0] OP_BREAK  = 8'h02;
  localparam logic [7:0] OP_CLOCKS = 8'h03;

  localparam logic [7:0] ARB_GRANT = 8'h5A;

  localparam int A_CMD  = 0;
  localparam int A_ARB  = 1;
  localparam int A_STAT = 2;
  localparam int A_ID   = 3;

  typedef enum logic [2:0] {
    F_INIT, F_IDLE, F_HOLD, F_XFER, F_CLOCKS
  } fsm_e;

  typedef enum logic [1:0] {
    K_NONE, K_XFER, K_BREAK, K_CLOCKS
  } kind_e;

  function automatic kind_e decode_op(input logic [OP_W-1:0] op);
    case (op)
      OP_XFER:   return K_XFER;
      OP_BREAK:  return K_BREAK;
      OP_CLOCKS: return K_CLOCKS;
      default:   return K_NONE;
    endcase
  endfunction

  function automatic logic is_final(input logic [7:0] s);
    return (s == ST_DONE) || s[7];
  endfunction

  function automatic logic [7:0] finish_code(input logic timed_out);
    return timed_out ? ST_ERR_NORESP : ST_DONE;
  endfunction

endpackage

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
#(
  parameter int          ADDR_W   = 2,
  parameter int          DATA_W   = 32,
  parameter logic [15:0] SIG_CODE = 16'h5EA1,
  parameter logic [7:0]  FW_REV   = 8'h03,
  parameter logic [7:0]  API_REV  = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              op_clear,
  input  logic              arb_grant,
  input  logic              stat_we,
  input  logic [7:0]        stat_nxt,
  output logic [DATA_W-1:0] cmd_q,
  output logic [7:0]        arb_q,
  output logic [7:0]        stat_q,
  output logic [15:0]       sig_q,
  output logic [7:0]        fw_q,
  output logic [7:0]        api_q,
  output logic              id_ready
);

  localparam logic [ADDR_W-1:0] SEL_CMD  = ADDR_W'(A_CMD);
  localparam logic [ADDR_W-1:0] SEL_ARB  = ADDR_W'(A_ARB);
  localparam logic [ADDR_W-1:0] SEL_STAT = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] SEL_ID   = ADDR_W'(A_ID);

  logic [1:0] init_step;
  logic       wr_cmd, wr_arb;

  assign wr_cmd   = wr && (addr == SEL_CMD);
  assign wr_arb   = wr && (addr == SEL_ARB);
  assign id_ready = (init_step == 2'd3);

  // identity fields fill in order; interface revision last
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_step <= 2'd0;
      sig_q     <= '0;
      fw_q      <= '0;
      api_q     <= '0;
    end else if (!id_ready) begin
      case (init_step)
        2'd0:    sig_q <= SIG_CODE;
        2'd1:    fw_q  <= FW_REV;
        2'd2:    api_q <= API_REV;
        default: ;
      endcase
      init_step <= init_step + 2'd1;
    end
  end

  // host write wins over the self-clear of the opcode byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (wr_cmd) begin
      cmd_q <= wdata;
    end else if (op_clear) begin
      cmd_q[OP_W-1:0] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_q <= '0;
    end else if (wr_arb) begin
      arb_q <= wdata[7:0];
    end else if (arb_grant) begin
      arb_q <= ARB_GRANT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= ST_IDLE;
    end else if (stat_we) begin
      stat_q <= stat_nxt;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      SEL_CMD:  rdata = cmd_q;
      SEL_ARB:  rdata = DATA_W'(arb_q);
      SEL_STAT: rdata = DATA_W'(stat_q);
      SEL_ID:   rdata = DATA_W'({api_q, fw_q, sig_q});
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/mbx_ctl.sv
module mbx_ctl
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_ready,
  input  logic [DATA_W-1:0] cmd_word,
  input  logic [7:0]        arb_val,
  input  logic              eng_done,
  input  logic              eng_timeout,
  input  logic              burst_done,
  output logic              op_clear,
  output logic              arb_grant,
  output logic              stat_we,
  output logic [7:0]        stat_nxt,
  output logic              irq,
  output logic              eng_start,
  output logic              eng_kind,
  output logic              burst_start,
  output logic [CNT_W-1:0]  burst_count,
  output logic              bad_op,
  output logic              hold,
  output logic              xfer_active
);

  fsm_e              state_q, state_d;
  logic [OP_W-1:0]   op;
  kind_e             kind;
  logic              irq_q;

  assign op          = cmd_word[OP_W-1:0];
  assign kind        = decode_op(op);
  assign burst_count = cmd_word[OP_W +: CNT_W];
  assign hold        = (state_q == F_HOLD);
  assign xfer_active = (state_q == F_XFER);
  assign irq         = irq_q;

  always_comb begin
    state_d     = state_q;
    op_clear    = 1'b0;
    arb_grant   = 1'b0;
    stat_we     = 1'b0;
    stat_nxt    = ST_IDLE;
    eng_start   = 1'b0;
    eng_kind    = 1'b0;
    burst_start = 1'b0;
    bad_op      = 1'b0;
    case (state_q)
      F_INIT: if (id_ready) state_d = F_IDLE;
      F_IDLE: begin
        if (arb_val != 8'h00) begin
          arb_grant = 1'b1;
          state_d   = F_HOLD;
        end else if (op != '0) begin
          op_clear = 1'b1;
          stat_we  = 1'b1;
          case (kind)
            K_XFER, K_BREAK: begin
              stat_nxt  = ST_SENDING;
              eng_start = 1'b1;
              eng_kind  = (kind == K_BREAK);
              state_d   = F_XFER;
            end
            K_CLOCKS: begin
              stat_nxt    = ST_SENDING;
              burst_start = 1'b1;
              state_d     = F_CLOCKS;
            end
            default: begin
              stat_nxt = ST_ERR_BADOP;
              bad_op   = 1'b1;
            end
          endcase
        end
      end
      F_HOLD: if (arb_val == 8'h00) state_d = F_IDLE;
      F_XFER: begin
        if (eng_done) begin
          stat_we  = 1'b1;
          stat_nxt = finish_code(eng_timeout);
          state_d  = F_IDLE;
        end
      end
      F_CLOCKS: begin
        if (burst_done) begin
          stat_we  = 1'b1;
          stat_nxt = ST_DONE;
          state_d  = F_IDLE;
        end
      end
      default: state_d = F_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= F_INIT;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= stat_we && is_final(stat_nxt);
    end
  end

endmodule

// File: rtl/mbx_burst.sv
module mbx_burst
  import mbx_pkg::*;
#(
  parameter int IDLE_HALF = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output logic             clk_o,
  output logic             busy,
  output logic             done
);

  localparam int DIV_W = (IDLE_HALF > 1) ? $clog2(IDLE_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LOAD = DIV_W'(IDLE_HALF - 1);

  logic             busy_q, low_q, done_q;
  logic [CNT_W-1:0] rem_q;
  logic [DIV_W-1:0] div_q;
  logic             phase_end;

  assign phase_end = (div_q == '0);
  assign clk_o     = !(busy_q && low_q);
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      low_q  <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
      div_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        if (count == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          low_q  <= 1'b1;
          rem_q  <= count;
          div_q  <= DIV_LOAD;
        end
      end else if (busy_q) begin
        if (!phase_end) begin
          div_q <= div_q - 1'b1;
        end else if (low_q) begin
          low_q <= 1'b0;
          div_q <= DIV_LOAD;
        end else if (rem_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          rem_q <= rem_q - 1'b1;
          low_q <= 1'b1;
          div_q <= DIV_LOAD;
        end
      end
    end
  end

endmodule

// File: rtl/mbx_pins.sv
module mbx_pins (
  input  logic hold,
  input  logic xfer_active,
  input  logic burst_busy,
  input  logic burst_clk,
  input  logic eng_clk,
  input  logic eng_dat,
  input  logic eng_dat_oe,
  output logic bus_clk,
  output logic bus_dat,
  output logic bus_dat_oe,
  output logic bus_host_owns
);

  always_comb begin
    bus_clk       = 1'b1;
    bus_dat       = 1'b1;
    bus_dat_oe    = 1'b1;
    bus_host_owns = 1'b0;
    if (hold) begin
      bus_dat_oe    = 1'b0;
      bus_host_owns = 1'b1;
    end else if (xfer_active) begin
      bus_clk    = eng_clk;
      bus_dat    = eng_dat;
      bus_dat_oe = eng_dat_oe;
    end else if (burst_busy) begin
      bus_clk = burst_clk;
    end
  end

endmodule

// File: rtl/mbx_dispatch.sv
module mbx_dispatch
  import mbx_pkg::*;
#(
  parameter int          ADDR_W    = 2,
  parameter int          DATA_W    = 32,
  parameter int          IDLE_HALF = 1,
  parameter logic [15:0] SIG_CODE  = 16'h5EA1,
  parameter logic [7:0]  FW_REV    = 8'h03,
  parameter logic [7:0]  API_REV   = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_irq,
  output logic              eng_start,
  output logic              eng_kind,
  output logic [DATA_W-9:0] eng_param,
  input  logic              eng_done,
  input  logic              eng_timeout,
  input  logic              eng_clk,
  input  logic              eng_dat,
  input  logic              eng_dat_oe,
  output logic              bus_clk,
  output logic              bus_dat,
  output logic              bus_dat_oe,
  output logic              bus_host_owns
);

  // named internal events, brought out for the checker
  logic              w_op_clear, w_grant, w_stat_we, w_id_ready;
  logic [7:0]        w_stat_nxt, w_arb, w_stat, w_fw, w_api;
  logic [15:0]       w_sig;
  logic [DATA_W-1:0] w_cmd;
  logic              w_burst_start, w_burst_busy, w_burst_done, w_burst_clk;
  logic [CNT_W-1:0]  w_burst_count;
  logic              w_bad_op, w_hold, w_xfer;

  assign eng_param = w_cmd[DATA_W-1:OP_W];

  mbx_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SIG_CODE(SIG_CODE), .FW_REV(FW_REV), .API_REV(API_REV)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr(host_wr), .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata),
    .op_clear(w_op_clear), .arb_grant(w_grant),
    .stat_we(w_stat_we), .stat_nxt(w_stat_nxt),
    .cmd_q(w_cmd), .arb_q(w_arb), .stat_q(w_stat),
    .sig_q(w_sig), .fw_q(w_fw), .api_q(w_api), .id_ready(w_id_ready)
  );

  mbx_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .id_ready(w_id_ready),
    .cmd_word(w_cmd), .arb_val(w_arb),
    .eng_done(eng_done), .eng_timeout(eng_timeout), .burst_done(w_burst_done),
    .op_clear(w_op_clear), .arb_grant(w_grant),
    .stat_we(w_stat_we), .stat_nxt(w_stat_nxt), .irq(host_irq),
    .eng_start(eng_start), .eng_kind(eng_kind),
    .burst_start(w_burst_start), .burst_count(w_burst_count),
    .bad_op(w_bad_op), .hold(w_hold), .xfer_active(w_xfer)
  );

  mbx_burst #(.IDLE_HALF(IDLE_HALF)) u_burst (
    .clk(clk), .rst_n(rst_n),
    .start(w_burst_start), .count(w_burst_count),
    .clk_o(w_burst_clk), .busy(w_burst_busy), .done(w_burst_done)
  );

  mbx_pins u_pins (
    .hold(w_hold), .xfer_active(w_xfer),
    .burst_busy(w_burst_busy), .burst_clk(w_burst_clk),
    .eng_clk(eng_clk), .eng_dat(eng_dat), .eng_dat_oe(eng_dat_oe),
    .bus_clk(bus_clk), .bus_dat(bus_dat), .bus_dat_oe(bus_dat_oe),
    .bus_host_owns(bus_host_owns)
  );

endmodule

// File: rtl/mbx_sva.sv
module mbx_sva
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_irq,
  input logic              hold,
  input logic              xfer,
  input logic              burst_busy,
  input logic              eng_start,
  input logic              burst_start,
  input logic              bad_op,
  input logic [7:0]        stat,
  input logic [7:0]        cmd_op,
  input logic [7:0]        arb,
  input logic [15:0]       sig,
  input logic [7:0]        fw,
  input logic [7:0]        api,
  input logic              bus_dat,
  input logic              bus_dat_oe,
  input logic              bus_host_owns
);

  logic host_cmd_wr, host_arb_wr;
  assign host_cmd_wr = host_wr && (host_addr == ADDR_W'(A_CMD));
  assign host_arb_wr = host_wr && (host_addr == ADDR_W'(A_ARB));

  assert_api_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (api != 8'h00) |-> (sig != 16'h0000) && (fw != 8'h00));

  assert_grant_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) && !$past(host_arb_wr) |-> (arb == ARB_GRANT));

  assert_hold_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> bus_host_owns && !bus_dat_oe);

  assert_no_start_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !eng_start && !burst_start);

  assert_reclaim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> bus_dat_oe && bus_dat && !bus_host_owns);

  assert_accept_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start || burst_start) && !host_cmd_wr |=> (stat == ST_SENDING) && (cmd_op == 8'h00));

  assert_burst_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    burst_busy |-> bus_dat && bus_dat_oe);

  assert_bad_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op && !host_cmd_wr |=> (stat == ST_ERR_BADOP) && (cmd_op == 8'h00));

  assert_irq_final_R12: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (stat == ST_DONE) || stat[7]);

  assert_single_owner_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hold, xfer, burst_busy}));

endmodule

bind mbx_dispatch mbx_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_irq(host_irq), .hold(w_hold), .xfer(w_xfer), .burst_busy(w_burst_busy),
  .eng_start(eng_start), .burst_start(w_burst_start), .bad_op(w_bad_op),
  .stat(w_stat), .cmd_op(w_cmd[7:0]), .arb(w_arb),
  .sig(w_sig), .fw(w_fw), .api(w_api),
  .bus_dat(bus_dat), .bus_dat_oe(bus_dat_oe), .bus_host_owns(bus_host_owns)
);

// File: tb/mbx_dispatch_bench.sv
`timescale 1ns/1ps
module mbx_dispatch_bench;

  localparam int          HALF = 2;
  localparam logic [15:0] SIG  = 16'hB00C;
  localparam logic [7:0]  FWV  = 8'h07;
  localparam logic [7:0]  APIV = 8'h02;
  localparam logic [1:0]  RA_CMD = 2'd0, RA_ARB = 2'd1, RA_STAT = 2'd2, RA_ID = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_irq, eng_start, eng_kind;
  logic [23:0] eng_param;
  logic        eng_done = 1'b0, eng_timeout = 1'b0;
  logic        eng_clk = 1'b1, eng_dat = 1'b1, eng_dat_oe = 1'b1;
  logic        bus_clk, bus_dat, bus_dat_oe, bus_host_owns;

  int n_chk = 0, n_bad = 0, irq_cnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n && host_irq) irq_cnt++;

  mbx_dispatch #(
    .IDLE_HALF(HALF), .SIG_CODE(SIG), .FW_REV(FWV), .API_REV(APIV)
  ) u_mbx_dispatch (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .eng_start(eng_start), .eng_kind(eng_kind), .eng_param(eng_param),
    .eng_done(eng_done), .eng_timeout(eng_timeout),
    .eng_clk(eng_clk), .eng_dat(eng_dat), .eng_dat_oe(eng_dat_oe),
    .bus_clk(bus_clk), .bus_dat(bus_dat), .bus_dat_oe(bus_dat_oe),
    .bus_host_owns(bus_host_owns)
  );

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    host_addr = a; #1; v = host_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic finish_engine(input logic tmo);
    eng_done = 1'b1; eng_timeout = tmo;
    tick();
    eng_done = 1'b0; eng_timeout = 1'b0;
  endtask

  // counts falling edges and low cycles of bus_clk until status reads complete
  task automatic watch_burst(input int n, input string req);
    int falls, lows, badpin;
    logic prev;
    logic [31:0] s;
    falls = 0; lows = 0; badpin = 0; prev = 1'b1; s = '0;
    for (int i = 0; i < 4 * n * HALF + 20; i++) begin
      tick();
      if (prev && !bus_clk) falls++;
      if (!bus_clk) lows++;
      if (!(bus_dat && bus_dat_oe)) badpin++;
      prev = bus_clk;
      rd(RA_STAT, s);
      if (s == 32'h2) break;
    end
    chk(req, "falling edges", falls, n);
    chk(req, "low cycles", lows, n * HALF);
    chk(req, "data not idle high", badpin, 0);
    chk(req, "burst status", s, 32'h2);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    rd(RA_ID, v);   chk("R2", "id right after reset", v, 32'h0);
    rd(RA_STAT, v); chk("R1", "status", v, 32'h0);
    rd(RA_ARB, v);  chk("R1", "arb", v, 32'h0);
    rd(RA_CMD, v);  chk("R1", "cmd", v, 32'h0);
    chk("R1", "pins", {host_irq, bus_clk, bus_dat, bus_dat_oe, bus_host_owns}, 5'b01110);
    tick();
    rd(RA_ID, v);   chk("R2", "iface rev still zero", v[31:24], 8'h00);
    tick(); tick();
    rd(RA_ID, v);   chk("R2", "id filled", v, {APIV, FWV, SIG});
    tick();
  endtask

  task automatic t_transfer();
    logic [31:0] v;
    int i0;
    i0 = irq_cnt;
    wr(RA_CMD, 32'h00AB_1001);
    chk("R7", "start pulse", eng_start, 1'b1);
    chk("R8", "kind transfer", eng_kind, 1'b0);
    chk("R8", "param", eng_param, 24'h00AB10);
    tick();
    chk("R7", "single start", eng_start, 1'b0);
    rd(RA_STAT, v); chk("R7", "sending", v, 32'h1);
    rd(RA_CMD, v);  chk("R7", "opcode cleared", v, 32'h00AB_1000);
    eng_clk = 1'b0; eng_dat = 1'b0; eng_dat_oe = 1'b0; #1;
    chk("R8", "engine owns pins", {bus_clk, bus_dat, bus_dat_oe}, 3'b000);
    finish_engine(1'b0);
    rd(RA_STAT, v); chk("R8", "complete", v, 32'h2);
    chk("R8", "pins idle after done", {bus_clk, bus_dat, bus_dat_oe}, 3'b111);
    chk("R12", "one irq", irq_cnt - i0, 1);
    eng_clk = 1'b1; eng_dat = 1'b1; eng_dat_oe = 1'b1;
    tick(); tick();
    chk("R12", "no further irq", irq_cnt - i0, 1);
  endtask

  task automatic t_break_timeout();
    logic [31:0] v;
    int i0;
    i0 = irq_cnt;
    wr(RA_CMD, 32'h0000_0002);
    chk("R8", "kind break", {eng_start, eng_kind}, 2'b11);
    tick(); tick();
    finish_engine(1'b1);
    rd(RA_STAT, v); chk("R9", "no-response code", v, 32'h81);
    chk("R12", "irq on error", irq_cnt - i0, 1);
  endtask

  task automatic t_clocks(input int n);
    int i0;
    i0 = irq_cnt;
    wr(RA_CMD, 32'(n << 8) | 32'h3);
    chk("R10", "no engine start", eng_start, 1'b0);
    watch_burst(n, "R10");
    tick();
    chk("R12", "irq after burst", irq_cnt - i0, 1);
  endtask

  task automatic t_invalid(input logic [7:0] op);
    logic [31:0] v;
    int i0;
    i0 = irq_cnt;
    wr(RA_CMD, {16'h0, 8'h05, op});
    chk("R11", "no start", eng_start, 1'b0);
    tick();
    rd(RA_STAT, v); chk("R11", "invalid code", v, 32'h80);
    rd(RA_CMD, v);  chk("R11", "opcode cleared", v, 32'h0000_0500);
    chk("R11", "clock idle", bus_clk, 1'b1);
    chk("R12", "irq on invalid", irq_cnt - i0, 1);
  endtask

  task automatic t_arbitration();
    logic [31:0] v;
    wr(RA_CMD, 32'h0000_0002);
    tick();
    wr(RA_ARB, 32'h1);
    wr(RA_CMD, 32'h0000_0203);
    tick();
    rd(RA_ARB, v);  chk("R13", "arb deferred while busy", v, 32'h1);
    rd(RA_CMD, v);  chk("R13", "cmd deferred while busy", v, 32'h0000_0203);
    chk("R13", "no host ownership yet", bus_host_owns, 1'b0);
    finish_engine(1'b0);
    tick();
    rd(RA_ARB, v);  chk("R3", "grant code", v, 32'h5A);
    chk("R3", "host owns pins", {bus_host_owns, bus_dat_oe}, 2'b10);
    rd(RA_CMD, v);  chk("R6", "cmd left pending", v, 32'h0000_0203);
    tick(); tick(); tick();
    rd(RA_CMD, v);  chk("R4", "cmd held", v, 32'h0000_0203);
    rd(RA_STAT, v); chk("R4", "status unchanged", v, 32'h2);
    chk("R4", "no start", eng_start, 1'b0);
    wr(RA_ARB, 32'h0);
    chk("R5", "still host until next edge", bus_host_owns, 1'b1);
    tick();
    chk("R5", "pins reclaimed", {bus_host_owns, bus_clk, bus_dat, bus_dat_oe}, 4'b0111);
    watch_burst(2, "R5");
  endtask

  initial begin
    t_reset();
    t_transfer();
    t_break_timeout();
    t_clocks(5);
    t_clocks(0);
    t_invalid(8'h07);
    t_invalid(8'hFF);
    t_arbitration();
    tick();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule